// File: doc/BRIEF.md
# Interrupt Routing Table Controller

This block steers up to 32 interrupt sources to a population of hardware threads (eight cores of four threads by default). Each source owns a pair of configuration words. One word is a destination mask with one bit per thread. The other word carries a valid flag, a trigger-mode flag, an enable flag and a vector number. Software reaches these words, a general control word and two command words through a simple word-addressed read/write port. Reads are combinational, and writes take effect at the clock edge.

Sources 1 to 8 are timer inputs. These are edge-captured: a rising edge latches a pending bit, and only a write-one to the acknowledge word clears it. Every other source is level-sensitive, so its pending bit simply follows the input one cycle later. For each thread, the controller looks at all pending sources whose entry is valid and enabled and whose mask selects that thread. The thread's interrupt output is raised, and the vector of the lowest-numbered such source is presented.

A single write to the inter-processor word names a core, a thread within that core, and a vector. That write marks an inter-processor request pending for the addressed thread. The thread clears the request with its own acknowledge strobe. While a request is pending, its vector takes precedence over any routed source vector for that thread.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, all pending state is zero, every thread output is low with a zero vector, and every configuration word reads back as zero.
- R2: Word address 0x00 is a 32-bit control word that reads back as written. Word 0x40+n holds the thread mask of source n in bits 31:0, and reads back as written. Word 0x80+n holds the route word of source n. Only bit 31 (valid), bit 30 (trigger setting), bit 6 (enable) and bits 5:0 (vector) are kept, and all other bits read as zero.
- R3: For every source other than 1 to 8, the pending bit equals the input as sampled at the previous clock edge. An acknowledge write has no effect on it.
- R4: For sources 1 to 8, a rising input edge sets the pending bit, which then stays set after the input falls. A write to word 0x06 with bit n set clears the pending bit of source n. A rising edge in the same cycle as the acknowledge wins, and the bit stays set.
- R5: A read of word 0x06 returns the 32-bit pending vector, with bit n belonging to source n.
- R6: Thread t is raised by source n only when the pending bit of n, bit 31 and bit 6 of its route word, and bit t of its mask are all set. If either bit 31 or bit 6 is clear, the entry raises nothing.
- R7: When several sources qualify for one thread, the vector presented is the one from the lowest-numbered source.
- R8: A write to word 0x04 takes the vector from bits 5:0, the thread from bits 17:16 and the core from bits 22:20. It selects thread index core*4+thread, marks an inter-processor request pending there, and stores the vector. The thread's bit of `thr_ack` clears the request. If a write and an acknowledge hit the same thread in the same cycle, the write wins.
- R9: While a thread has an inter-processor request pending, its output is high and its vector is the request's vector, whatever sources are routed to it.
- R10: The output for thread t is bit t of `thr_irq` and bits t*6+5:t*6 of `thr_vec`. When the output is low, the vector field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_in | input | 32 | Interrupt source inputs |
| thr_ack | input | 32 | Per-thread strobe that clears an inter-processor request |
| thr_irq | output | 32 | Per-thread interrupt request |
| thr_vec | output | 192 | Per-thread vector, 6 bits per thread |

## Verification
Every result becomes visible one clock edge after its cause: a source change, a configuration write, an acknowledge, an inter-processor write or a thread strobe each show on the outputs after the next rising edge. Read data is valid in the same cycle the address is applied. The bench drives stimulus on the falling edge and advances its own model at the rising edge. It then compares all thread outputs at the following falling edge, so each comparison lands exactly one register stage after the stimulus. Reads are checked a short delay after the address is applied, before the next rising edge, against the model's state at that moment.

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NSRC    = 32,
  parameter int NCORE   = 8,
  parameter int NTHR    = 4,
  parameter int VEC_W   = 6,
  parameter int ADDR_W  = 8,
  parameter int EDGE_LO = 1,
  parameter int EDGE_HI = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NSRC-1:0]         src_in,
  input  logic [NCORE*NTHR-1:0]   thr_ack,
  output logic [NCORE*NTHR-1:0]   thr_irq,
  output logic [NCORE*NTHR*VEC_W-1:0] thr_vec
);
  localparam int NT    = NCORE * NTHR;
  localparam int IDX_W = $clog2(NSRC);
  localparam int TID_W = $clog2(NTHR);
  localparam int CID_W = $clog2(NCORE);
  localparam int TGT_W = TID_W + CID_W;
  localparam int IPI_TID_LSB = 16;
  localparam int IPI_CID_LSB = 20;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_IPI   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(8'h80);

  function automatic logic [NSRC-1:0] edge_map();
    logic [NSRC-1:0] m;
    for (int i = 0; i < NSRC; i++) m[i] = (i >= EDGE_LO) && (i <= EDGE_HI);
    return m;
  endfunction
  localparam logic [NSRC-1:0] EDGE_MAP = edge_map();

  logic [31:0]      ctrl_q;
  logic [NT-1:0]    mask_q [NSRC];
  logic [NSRC-1:0]  rvalid_q, rlvl_q, ren_q;
  logic [VEC_W-1:0] rvec_q [NSRC];
  logic [NSRC-1:0]  src_q, pend_q;
  logic [NT-1:0]    ipi_pend_q;
  logic [VEC_W-1:0] ipi_vec_q [NT];

  logic [ADDR_W-1:0] moff, roff;
  logic [IDX_W-1:0]  midx, ridx;
  logic in_mask, in_route, wr_ctrl, wr_ipi, wr_ack, wr_mask, wr_route;
  logic [TGT_W-1:0]  ipi_tgt;
  logic [NSRC-1:0]   rise, ack_v, pend_d, route_ok, live;

  assign moff     = reg_addr - A_MASK;
  assign roff     = reg_addr - A_ROUTE;
  assign midx     = moff[IDX_W-1:0];
  assign ridx     = roff[IDX_W-1:0];
  assign in_mask  = (reg_addr >= A_MASK)  && (moff < ADDR_W'(NSRC));
  assign in_route = (reg_addr >= A_ROUTE) && (roff < ADDR_W'(NSRC));
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_ipi   = reg_wr && (reg_addr == A_IPI);
  assign wr_ack   = reg_wr && (reg_addr == A_ACK);
  assign wr_mask  = reg_wr && in_mask;
  assign wr_route = reg_wr && in_route;
  assign ipi_tgt  = {reg_wdata[IPI_CID_LSB +: CID_W], reg_wdata[IPI_TID_LSB +: TID_W]};

  assign rise     = src_in & ~src_q;
  assign ack_v    = wr_ack ? reg_wdata[NSRC-1:0] : '0;
  assign pend_d   = (EDGE_MAP & ((pend_q & ~ack_v) | rise)) | (~EDGE_MAP & src_in);
  assign route_ok = rvalid_q & ren_q;
  assign live     = pend_q & route_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      rvalid_q   <= '0;
      rlvl_q     <= '0;
      ren_q      <= '0;
      src_q      <= '0;
      pend_q     <= '0;
      ipi_pend_q <= '0;
      for (int n = 0; n < NSRC; n++) begin
        mask_q[n] <= '0;
        rvec_q[n] <= '0;
      end
      for (int t = 0; t < NT; t++) ipi_vec_q[t] <= '0;
    end else begin
      src_q  <= src_in;
      pend_q <= pend_d;
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (wr_mask) mask_q[midx] <= reg_wdata[NT-1:0];
      if (wr_route) begin
        rvalid_q[ridx] <= reg_wdata[31];
        rlvl_q[ridx]   <= reg_wdata[30];
        ren_q[ridx]    <= reg_wdata[6];
        rvec_q[ridx]   <= reg_wdata[VEC_W-1:0];
      end
      ipi_pend_q <= ipi_pend_q & ~thr_ack;
      if (wr_ipi) begin
        ipi_pend_q[ipi_tgt] <= 1'b1;
        ipi_vec_q[ipi_tgt]  <= reg_wdata[VEC_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata = ctrl_q;
    else if (reg_addr == A_ACK) reg_rdata[NSRC-1:0] = pend_q;
    else if (in_mask) reg_rdata[NT-1:0] = mask_q[midx];
    else if (in_route) begin
      reg_rdata[31]        = rvalid_q[ridx];
      reg_rdata[30]        = rlvl_q[ridx];
      reg_rdata[6]         = ren_q[ridx];
      reg_rdata[VEC_W-1:0] = rvec_q[ridx];
    end
  end

  genvar t;
  generate
    for (t = 0; t < NT; t++) begin : g_thr
      logic             hit;
      logic [VEC_W-1:0] sv;
      always_comb begin
        hit = 1'b0;
        sv  = '0;
        for (int n = NSRC - 1; n >= 0; n--) begin
          if (live[n] && mask_q[n][t]) begin
            hit = 1'b1;
            sv  = rvec_q[n];
          end
        end
      end
      assign thr_irq[t] = hit | ipi_pend_q[t];
      assign thr_vec[t*VEC_W +: VEC_W] = ipi_pend_q[t] ? ipi_vec_q[t] : (hit ? sv : '0);
    end
  endgenerate

  assert_level_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~EDGE_MAP) == ($past(src_in) & ~EDGE_MAP)));

  assert_ack_clears_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((pend_q & EDGE_MAP & $past(reg_wdata[NSRC-1:0] & ~rise)) == '0));

  assert_no_route_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (route_ok == '0) |-> ((thr_irq & ~ipi_pend_q) == '0));

  assert_ipi_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ipi |=> ipi_pend_q[$past(ipi_tgt)]);

  assert_ipi_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ipi |=> thr_irq[$past(ipi_tgt)]);
endmodule

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;
  localparam int NT = 32;
  localparam int VW = 6;
  localparam logic [31:0] EDGE = 32'h0000_01FE;
  localparam logic [31:0] KEEP = 32'hC000_007F;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, reg_wr;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, src_in, thr_ack, thr_irq;
  logic [NT*VW-1:0] thr_vec;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl, m_pend, m_srcq, m_ipi;
  logic [31:0] m_mask [32];
  logic [31:0] m_rw1 [32];
  logic [5:0]  m_ivec [32];

  irq_route_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in), .thr_ack(thr_ack),
    .thr_irq(thr_irq), .thr_vec(thr_vec));

  task automatic check(input string req, input logic [NT*VW-1:0] act, input logic [NT*VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = '0; m_pend = '0; m_srcq = '0; m_ipi = '0;
    for (int i = 0; i < 32; i++) begin m_mask[i] = '0; m_rw1[i] = '0; m_ivec[i] = '0; end
  endtask

  task automatic model_step();
    logic [31:0] ackv, rise;
    int tg;
    ackv = (reg_wr && reg_addr == 8'h06) ? reg_wdata : '0;
    rise = src_in & ~m_srcq;
    m_pend = (EDGE & ((m_pend & ~ackv) | rise)) | (~EDGE & src_in);
    m_srcq = src_in;
    m_ipi = m_ipi & ~thr_ack;
    if (reg_wr) begin
      if (reg_addr == 8'h00) m_ctrl = reg_wdata;
      else if (reg_addr == 8'h04) begin
        tg = int'(reg_wdata[22:20]) * 4 + int'(reg_wdata[17:16]);
        m_ipi[tg] = 1'b1;
        m_ivec[tg] = reg_wdata[5:0];
      end
      else if (reg_addr >= 8'h40 && reg_addr < 8'h60) m_mask[reg_addr - 8'h40] = reg_wdata;
      else if (reg_addr >= 8'h80 && reg_addr < 8'hA0) m_rw1[reg_addr - 8'h80] = reg_wdata & KEEP;
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return m_ctrl;
    if (a == 8'h06) return m_pend;
    if (a >= 8'h40 && a < 8'h60) return m_mask[a - 8'h40];
    if (a >= 8'h80 && a < 8'hA0) return m_rw1[a - 8'h80];
    return '0;
  endfunction

  task automatic exp_out(output logic [31:0] irq, output logic [NT*VW-1:0] vec);
    irq = '0; vec = '0;
    for (int t = 0; t < NT; t++) begin
      bit hit = 1'b0;
      logic [5:0] sv = '0;
      for (int n = 0; n < 32; n++)
        if (!hit && m_pend[n] && m_rw1[n][31] && m_rw1[n][6] && m_mask[n][t]) begin
          hit = 1'b1; sv = m_rw1[n][5:0];
        end
      irq[t] = hit | m_ipi[t];
      vec[t*VW +: VW] = m_ipi[t] ? m_ivec[t] : (hit ? sv : 6'd0);
    end
  endtask

  task automatic cyc();
    logic [31:0] ei;
    logic [NT*VW-1:0] ev;
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    exp_out(ei, ev);
    check("R6 R7 R9 R10 irq", {160'd0, thr_irq}, {160'd0, ei});
    check("R6 R7 R9 R10 vec", thr_vec, ev);
    reg_wr = 1'b0;
    thr_ack = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
  endtask

  task automatic rd_check(input logic [7:0] a, input string req);
    reg_wr = 1'b0; reg_addr = a;
    #0.5;
    check(req, {160'd0, reg_rdata}, {160'd0, exp_read(a)});
  endtask

  task automatic thr_check(input int t, input logic irq, input logic [5:0] v, input string req);
    check(req, {185'd0, thr_irq[t], thr_vec[t*VW +: VW]}, {185'd0, irq, v});
  endtask

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; src_in = '0; thr_ack = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {160'd0, thr_irq}, '0);
    check("R1 vec", thr_vec, '0);
    rd_check(8'h06, "R1 pending");
    rd_check(8'h85, "R1 route word");
    rd_check(8'h45, "R1 mask word");
    rst_n = 1'b1;
    cyc();

    // R2 readback
    wr(8'h45, 32'hA5A5_0F0F); rd_check(8'h45, "R2 mask");
    check("R2 mask literal", {160'd0, reg_rdata}, {160'd0, 32'hA5A5_0F0F});
    wr(8'h85, 32'hFFFF_FFFF); rd_check(8'h85, "R2 route");
    check("R2 route literal", {160'd0, reg_rdata}, {160'd0, 32'hC000_007F});
    wr(8'h00, 32'h1234_5678); rd_check(8'h00, "R2 ctrl");
    wr(8'h85, 32'h0); wr(8'h45, 32'h0);

    // R4 edge source 3 -> thread 5, vector 0x13
    wr(8'h83, 32'h8000_0053); wr(8'h43, 32'h0000_0020);
    src_in[3] = 1'b1; cyc();
    thr_check(5, 1'b1, 6'h13, "R4 edge latch");
    src_in[3] = 1'b0; cyc();
    thr_check(5, 1'b1, 6'h13, "R4 edge held");
    wr(8'h06, 32'h0000_0008);
    thr_check(5, 1'b0, 6'h00, "R4 ack clears");
    src_in[3] = 1'b1; wr(8'h06, 32'h0000_0008);
    rd_check(8'h06, "R5 pending read");
    check("R4 rise beats ack", {191'd0, reg_rdata[3]}, {191'd0, 1'b1});
    src_in[3] = 1'b0; wr(8'h06, 32'h0000_0008);

    // R3 level source 12 -> thread 5, vector 0x2A
    wr(8'h8C, 32'h8000_006A); wr(8'h4C, 32'h0000_0020);
    src_in[12] = 1'b1; cyc();
    thr_check(5, 1'b1, 6'h2A, "R3 level raise");
    wr(8'h06, 32'h0000_1000);
    rd_check(8'h06, "R3 ack ignored");
    check("R3 still pending", {191'd0, reg_rdata[12]}, {191'd0, 1'b1});
    src_in[12] = 1'b0; cyc();
    thr_check(5, 1'b0, 6'h00, "R3 level drop");

    // R6 valid/enable gating
    src_in[12] = 1'b1;
    wr(8'h8C, 32'h8000_002A);
    thr_check(5, 1'b0, 6'h00, "R6 enable clear");
    wr(8'h8C, 32'h4000_006A);
    thr_check(5, 1'b0, 6'h00, "R6 valid clear");
    wr(8'h8C, 32'h8000_006A);
    thr_check(5, 1'b1, 6'h2A, "R6 valid and enabled");

    // R7 lowest index wins
    wr(8'h94, 32'h8000_0045); wr(8'h54, 32'h0000_0820);
    src_in[20] = 1'b1; cyc();
    thr_check(5, 1'b1, 6'h2A, "R7 lower index wins");
    src_in[12] = 1'b0; cyc();
    thr_check(5, 1'b1, 6'h05, "R7 next source");

    // R8 / R9 inter-processor request: core 2 thread 3 -> index 11
    wr(8'h04, (32'd2 << 20) | (32'd3 << 16) | 32'h31);
    thr_check(11, 1'b1, 6'h31, "R8 ipi target");
    thr_check(10, 1'b0, 6'h00, "R8 ipi neighbour");
    cyc();
    thr_check(11, 1'b1, 6'h31, "R9 ipi over source");
    thr_ack[11] = 1'b1; cyc();
    thr_check(11, 1'b1, 6'h05, "R8 ipi ack");
    thr_ack[11] = 1'b1;
    wr(8'h04, (32'd2 << 20) | (32'd3 << 16) | 32'h0E);
    thr_check(11, 1'b1, 6'h0E, "R8 write beats ack");
    thr_ack[11] = 1'b1; cyc();

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      src_in = src_in ^ ($urandom() & $urandom() & $urandom());
      if ($urandom_range(0, 3) == 0) thr_ack = $urandom() & $urandom();
      case (op)
        0: begin
          logic [31:0] d = $urandom();
          if ($urandom_range(0, 3) != 0) d = d | 32'h8000_0040;
          wr(8'h80 + 8'($urandom_range(0, 31)), d);
        end
        1: wr(8'h40 + 8'($urandom_range(0, 31)), $urandom() & $urandom());
        2: wr(8'h06, $urandom());
        3: wr(8'h04, $urandom());
        4: begin
          logic [7:0] a;
          case ($urandom_range(0, 3))
            0: a = 8'h06;
            1: a = 8'h40 + 8'($urandom_range(0, 31));
            2: a = 8'h80 + 8'($urandom_range(0, 31));
            default: a = 8'h00;
          endcase
          rd_check(a, "R2 R5 random read");
          cyc();
        end
        5: wr(8'h00, $urandom());
        default: cyc();
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule